// File: doc/BRIEF.md
# Target Agent Bus Error Logger

This block sits beside one target agent of an on-chip interconnect and records failed requests. A single-cycle error strobe on the target path comes with the failing address, a 16-bit requester-info sideband, a 3-bit command code and three cause flags. On that strobe the block packs a 32-bit attribute word, stores it together with the address in 64-bit registers, sets a sticky pending bit and raises an interrupt level.

Two copies of the log are kept: one for Secure and one for Non-Secure traffic. A failing transaction goes to the Secure copy only when it is marked Secure and comes from a processor. Every other error, including all errors from DMA engines and other non-processor initiators, goes to the Non-Secure copy. Each copy has its own interrupt output. Software reaches the copy chosen by a bank-select input through a simple read/write port over a 1 KiB window of 64-bit registers. It clears a pending error by writing the status register with the pending bit set. While an error is pending, the first error is held and later ones for that copy are dropped.

Top module: `errlog_top`

## Requirements
- R1: After reset both pending bits are 0, both interrupt outputs are low, and the status, attribute and address registers of both banks read 0.
- R2: The attribute register (offset 0x058) reads a 32-bit word zero-extended to 64 bits, built as follows:
  - bits 31:23 hold requester info bits 15:7;
  - bits 21:16 hold the low six bits of the master ID, which is requester info bits 5:0;
  - bits 10:8 hold the command code (0 idle, 1 write, 2 read, 3 read-exclusive, 4 read-linked, 5 non-posted write, 6 write-conditional, 7 broadcast);
  - bit 3 holds the burst error flag, bit 2 the register permission flag and bit 0 the address hole flag;
  - bits 22, 15:11, 7:4 and 1 read as 0.
- R3: The address register (offset 0x060) reads the failing address zero-extended to 64 bits.
- R4: Status (offset 0x028) bit 24 is the pending bit of the selected bank, and every other status bit reads 0. The pending bit is 1 from the clock edge that samples an error strobe for that bank.
- R5: An error with errSecure=1 and errFromCpu=1 updates only the Secure bank (regSecure=1) and raises only irqSecure.
- R6: An error with errFromCpu=0 updates only the Non-Secure bank (regSecure=0) and raises only irqNonSecure, whatever errSecure is.
- R7: While a bank is pending, later errors for that bank leave its attribute and address registers unchanged.
- R8: A write to offset 0x028 with data bit 24 set clears the pending bit of the bank chosen by regSecure from the next edge. The other bank is unaffected. A status write with bit 24 clear has no effect.
- R9: When an error for a bank and a clear of that bank come on the same edge, the new error is captured and the bank stays pending.
- R10: Reads of any offset other than 0x028, 0x058 and 0x060 return 0, and writes to those offsets change no register.
- R11: irqSecure and irqNonSecure are each equal at all times to the pending bit of their bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | One-cycle strobe: a request failed |
| errAddr | input | ADDR_W | Failing request address |
| errReqInfo | input | 16 | Requester info sideband; bits 6:0 are the master ID |
| errCmd | input | 3 | Command code of the failing request |
| errSecure | input | 1 | Security bit of the failing request |
| errFromCpu | input | 1 | 1 when the initiator is a processor |
| errBurst | input | 1 | Cause flag: burst access error |
| errPerm | input | 1 | Cause flag: register permission error |
| errHole | input | 1 | Cause flag: address hole |
| regAddr | input | OFF_W | Byte offset of the register access |
| regSecure | input | 1 | Bank selected for the access (1 Secure) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data (combinational) |
| irqSecure | output | 1 | Secure bank error interrupt level |
| irqNonSecure | output | 1 | Non-Secure bank error interrupt level |

## Verification
The bench sweeps all eight command codes against all eight combinations of the three cause flags. Each combination is paired with a requester-info value derived from the loop indices, so a swapped or shifted field shows up as a wrong bit in a known place. Every combination is run once in each bank, which separates errors in the bank steering from errors in the packing. Further patterns cover a held first error under a second error, a clear with the pending bit missing, an error and a clear on the same edge, a Secure-marked error from a non-processor, and accesses to undefined offsets.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int NBANK  = 2;
  localparam int BANK_NS = 0;
  localparam int BANK_S  = 1;
  localparam int REQ_W   = 16;
  localparam int CMD_W   = 3;
  localparam int PEND_BIT = 24;
  localparam logic [9:0] STAT_OFF = 10'h028;
  localparam logic [9:0] ATTR_OFF = 10'h058;
  localparam logic [9:0] ADDR_OFF = 10'h060;
  localparam logic [31:0] ATTR_DEF_MASK = 32'hFFBF_070D;

  typedef struct packed {
    logic [NBANK-1:0] capture;
    logic [NBANK-1:0] pending;
  } ctrlStrobes_t;

  function automatic logic [31:0] packAttr(input logic [REQ_W-1:0] reqInfo,
                                           input logic [CMD_W-1:0] cmd,
                                           input logic burst, input logic perm,
                                           input logic hole);
    logic [31:0] w;
    w = '0;
    w[31:23] = reqInfo[15:7];
    w[21:16] = reqInfo[5:0];
    w[10:8]  = cmd;
    w[3]     = burst;
    w[2]     = perm;
    w[0]     = hole;
    return w;
  endfunction
endpackage

// File: rtl/errlog_ctrl.sv
module errlog_ctrl
  import errlog_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errValid,
  input  logic             errSecure,
  input  logic             errFromCpu,
  input  logic             regWrEn,
  input  logic [OFF_W-1:0] regAddr,
  input  logic             regWrPendBit,
  input  logic             regSecure,
  output ctrlStrobes_t     strobes,
  output logic [NBANK-1:0] irq
);
  logic [NBANK-1:0] pendQ;
  logic [NBANK-1:0] capStb;
  logic [NBANK-1:0] clrStb;
  logic             secureHit;
  logic             statWrite;

  // Non-processor initiators are always steered to the Non-Secure bank.
  assign secureHit = errSecure & errFromCpu;
  assign statWrite = regWrEn & (regAddr == OFF_W'(STAT_OFF)) & regWrPendBit;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bankHit;
    assign bankHit   = (b == BANK_S) ? secureHit : ~secureHit;
    assign clrStb[b] = statWrite & (regSecure == (b == BANK_S));
    // A capture is allowed when idle, or when the same edge clears the bank.
    assign capStb[b] = errValid & bankHit & (~pendQ[b] | clrStb[b]);

    always_ff @(posedge clk) begin
      if (!rstN) pendQ[b] <= 1'b0;
      else if (capStb[b]) pendQ[b] <= 1'b1;
      else if (clrStb[b]) pendQ[b] <= 1'b0;
    end

    assert_capture_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      capStb[b] |=> pendQ[b]);
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clrStb[b] && !capStb[b]) |=> !pendQ[b]);
    assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[b] && !clrStb[b]) |=> pendQ[b]);
    assert_race_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
      (errValid && bankHit && clrStb[b]) |=> pendQ[b]);
  end

  assert_dma_not_secure_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errFromCpu && !pendQ[BANK_S]) |=> !pendQ[BANK_S]);

  assign strobes.capture = capStb;
  assign strobes.pending = pendQ;
  assign irq             = pendQ;
endmodule

// File: rtl/errlog_dp.sv
module errlog_dp
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [REQ_W-1:0]  errReqInfo,
  input  logic [CMD_W-1:0]  errCmd,
  input  logic              errBurst,
  input  logic              errPerm,
  input  logic              errHole,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic              regSecure,
  output logic [63:0]       regRdData
);
  logic [31:0]       attrNext;
  logic [31:0]       attrLog [NBANK];
  logic [ADDR_W-1:0] addrLog [NBANK];
  int unsigned       selBank;

  assign attrNext = packAttr(errReqInfo, errCmd, errBurst, errPerm, errHole);

  for (genvar b = 0; b < NBANK; b++) begin : g_log
    always_ff @(posedge clk) begin
      if (!rstN) begin
        attrLog[b] <= '0;
        addrLog[b] <= '0;
      end else if (strobes.capture[b]) begin
        attrLog[b] <= attrNext;
        addrLog[b] <= errAddr;
      end
    end

    assert_log_held_R7: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.capture[b] |=> ($stable(attrLog[b]) && $stable(addrLog[b])));
  end

  assign selBank = regSecure ? BANK_S : BANK_NS;

  always_comb begin
    regRdData = '0;
    if (regAddr == OFF_W'(STAT_OFF))
      regRdData[PEND_BIT] = strobes.pending[selBank];
    else if (regAddr == OFF_W'(ATTR_OFF))
      regRdData[31:0] = attrLog[selBank];
    else if (regAddr == OFF_W'(ADDR_OFF))
      regRdData[ADDR_W-1:0] = addrLog[selBank];
  end
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [15:0]       errReqInfo,
  input  logic [2:0]        errCmd,
  input  logic              errSecure,
  input  logic              errFromCpu,
  input  logic              errBurst,
  input  logic              errPerm,
  input  logic              errHole,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic              regSecure,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              irqSecure,
  output logic              irqNonSecure
);
  ctrlStrobes_t     strobes;
  logic [NBANK-1:0] irq;

  errlog_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errSecure(errSecure),
    .errFromCpu(errFromCpu), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrPendBit(regWrData[PEND_BIT]), .regSecure(regSecure),
    .strobes(strobes), .irq(irq)
  );

  errlog_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .errAddr(errAddr),
    .errReqInfo(errReqInfo), .errCmd(errCmd), .errBurst(errBurst),
    .errPerm(errPerm), .errHole(errHole), .regAddr(regAddr),
    .regSecure(regSecure), .regRdData(regRdData)
  );

  assign irqSecure    = irq[BANK_S];
  assign irqNonSecure = irq[BANK_NS];

  assert_attr_undef_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_W'(ATTR_OFF)) |-> ((regRdData & ~{32'h0, ATTR_DEF_MASK}) == 64'h0));
  assert_irq_rises_R11: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errSecure && errFromCpu) |=> irqSecure);
  assert_undef_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != OFF_W'(STAT_OFF) && regAddr != OFF_W'(ATTR_OFF) &&
     regAddr != OFF_W'(ADDR_OFF)) |-> (regRdData == 64'h0));
endmodule

// File: tb/errlog_top_bench.sv
`timescale 1ns/1ps
module errlog_top_bench;
  localparam int ADDR_W = 40;
  logic clk = 0, rstN = 0;
  logic errValid = 0, errSecure = 0, errFromCpu = 0, errBurst = 0, errPerm = 0, errHole = 0;
  logic [ADDR_W-1:0] errAddr = '0;
  logic [15:0] errReqInfo = '0;
  logic [2:0] errCmd = '0;
  logic [9:0] regAddr = '0;
  logic regSecure = 0, regWrEn = 0;
  logic [63:0] regWrData = '0, regRdData;
  logic irqSecure, irqNonSecure;
  int testCount = 0, failCount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  errlog_top #(.ADDR_W(ADDR_W), .OFF_W(10)) u_errlog_top (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, input logic s, output logic [63:0] d);
    regAddr = a; regSecure = s; #1; d = regRdData;
  endtask

  task automatic fire(input logic sec, input logic cpu, input logic [ADDR_W-1:0] a,
                      input logic [15:0] ri, input logic [2:0] c, input logic [2:0] f);
    @(negedge clk);
    errValid = 1; errSecure = sec; errFromCpu = cpu; errAddr = a; errReqInfo = ri;
    errCmd = c; {errBurst, errPerm, errHole} = f;
    @(negedge clk);
    errValid = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic s, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regSecure = s; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  function automatic logic [63:0] expAttr(input logic [15:0] ri, input logic [2:0] c, input logic [2:0] f);
    return 64'(ri[15:7]) * 64'h80_0000 + 64'(ri[5:0]) * 64'h1_0000 + 64'(c) * 64'h100
           + 64'(f[2]) * 8 + 64'(f[1]) * 4 + 64'(f[0]);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      failCount++; testCount++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [15:0] ri;
    logic [ADDR_W-1:0] ad;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!irqSecure && !irqNonSecure, "R1 irq", {irqSecure, irqNonSecure}, 0);
    for (int s = 0; s < 2; s++) begin
      rd(10'h028, s[0], d); check(d == 0, "R1 status", d, 0);
      rd(10'h058, s[0], d); check(d == 0, "R1 attr", d, 0);
      rd(10'h060, s[0], d); check(d == 0, "R1 addr", d, 0);
    end
    // R2 R3 R4 R5 R6 R11 sweep: cmd x flags x bank
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 8; f++) begin
          ri = 16'((c * 8 + f) * 16'h0A53 + s * 16'h1111);
          ad = ADDR_W'(64'h12_3400_0000 + c * 64'h100 + f * 8 + s);
          fire(s[0], (s == 1) ? 1'b1 : 1'(f & 1), ad, ri, c[2:0], f[2:0]);
          check(irqSecure == s[0] && irqNonSecure == !s[0], "R5 R11 irq steer",
                {irqSecure, irqNonSecure}, {s[0], !s[0]});
          rd(10'h058, s[0], d); check(d == expAttr(ri, c[2:0], f[2:0]), "R2 attr", d, expAttr(ri, c[2:0], f[2:0]));
          rd(10'h060, s[0], d); check(d == 64'(ad), "R3 addr", d, 64'(ad));
          rd(10'h028, s[0], d); check(d == 64'h100_0000, "R4 status", d, 64'h100_0000);
          rd(10'h028, !s[0], d); check(d == 0, "R5 R6 other bank", d, 0);
          wr(10'h028, s[0], 64'h100_0000);
          check(!irqSecure && !irqNonSecure, "R8 clear", {irqSecure, irqNonSecure}, 0);
        end
    // R6 secure-marked DMA goes Non-Secure
    fire(1, 0, 40'hAB, 16'h0011, 3'd2, 3'b001);
    check(irqNonSecure && !irqSecure, "R6 dma", {irqSecure, irqNonSecure}, 2'b01);
    rd(10'h060, 0, d); check(d == 64'hAB, "R6 ns addr", d, 64'hAB);
    // R7 first error held
    fire(0, 1, 40'hCD, 16'h0022, 3'd1, 3'b100);
    rd(10'h060, 0, d); check(d == 64'hAB, "R7 addr held", d, 64'hAB);
    rd(10'h058, 0, d); check(d == expAttr(16'h0011, 3'd2, 3'b001), "R7 attr held", d, expAttr(16'h0011, 3'd2, 3'b001));
    // R8 write without bit 24 ignored; clear of other bank ignored
    wr(10'h028, 0, 64'hFEFF_FFFF);
    check(irqNonSecure, "R8 no bit24", irqNonSecure, 1);
    wr(10'h028, 1, 64'h100_0000);
    check(irqNonSecure, "R8 other bank", irqNonSecure, 1);
    // R9 error and clear same edge
    @(negedge clk);
    errValid = 1; errSecure = 0; errFromCpu = 1; errAddr = 40'hEF; errReqInfo = 16'h0033;
    errCmd = 3'd5; {errBurst, errPerm, errHole} = 3'b010;
    regWrEn = 1; regAddr = 10'h028; regSecure = 0; regWrData = 64'h100_0000;
    @(negedge clk);
    errValid = 0; regWrEn = 0;
    check(irqNonSecure, "R9 still pending", irqNonSecure, 1);
    rd(10'h060, 0, d); check(d == 64'hEF, "R9 new addr", d, 64'hEF);
    // R10 undefined offsets
    for (int o = 0; o < 1024; o += 8) begin
      if (o == 'h28 || o == 'h58 || o == 'h60) continue;
      wr(10'(o), 0, '1);
      rd(10'(o), 0, d); check(d == 0, "R10 undef read", d, 0);
    end
    rd(10'h060, 0, d); check(d == 64'hEF, "R10 addr untouched", d, 64'hEF);
    check(irqNonSecure, "R10 pending untouched", irqNonSecure, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule